// File: doc/BRIEF.md
# Delay Line Step Controller

This block sequences tap adjustments on a bank of programmable delay elements. Each channel owns two elements: a capture-path delay and an IO-path delay. A command names its target through a unit ID. One-cycle command pulses ask for a single tap step, for a burst of N steps, or for a return to the element's configured default tap. A direction input chooses whether a step raises or lowers the delay.

The controller keeps a shadow tap count for every element. It emits one step strobe per tap move together with a shared direction line, or a load strobe for a return to default. It reports busy while a sequence runs. In a burst, steps are separated by a fixed number of idle clocks so the delay primitive can settle. A step that would push an element past tap 0 or past its top tap is not issued. Instead it raises a sticky end-of-range flag, which stays set until software clears it.

The state machine has four states:
- **IDLE** is the only state that accepts commands.
- **IDLE → STEP** happens on an accepted single or burst command.
- **IDLE → LOAD** happens on an accepted default command.
- **STEP → SETTLE** happens when steps remain.
- **STEP → IDLE** happens after the last step.
- **SETTLE → STEP** happens after the idle gap has elapsed.
- **LOAD → IDLE** always follows after one cycle.

Top module: `delay_step_ctrl`

## Requirements
- R1: An accepted single-step command moves the addressed element by exactly one tap. It produces one strobe on `step_o` in the cycle after acceptance. `dir_o` shows the latched direction (0 = increase, 1 = decrease) and holds steady while busy.
- R2: The unit ID is 4*c+k. k=0 selects the capture delay of channel c, which is element 2c. k=1 selects the IO delay of channel c, which is element 2c+1. An ID with k=2 or k=3, or with c ≥ NUM_CH, is ignored: no strobe is issued and busy stays low.
- R3: A burst command performs N steps, where N is bits [6:0] of `burst_len_i`. Consecutive strobes are separated by exactly SETTLE_GAP idle cycles. N=0 is a no-op.
- R4: An accepted default command produces a single one-cycle strobe on `load_o` for the addressed element in the cycle after acceptance. It returns that element's tap to TAP_DEFAULT, and busy falls in the following cycle.
- R5: `busy_o` is high from the cycle after acceptance through the cycle of the last strobe. A burst of N is busy for 1+(N-1)*(SETTLE_GAP+1) cycles. Any strobe implies busy.
- R6: Any command that arrives while busy is ignored.
- R7: A step that would go below tap 0 or above tap 2^TAP_W-1 issues no strobe, still uses its slot in the sequence, and sets `eor_o`.
- R8: `eor_o` is sticky. It clears only when `clr_eor_i` is asserted, and a pulse while idle clears it in the next cycle.
- R9: When several commands arrive in one cycle, default wins over burst, and burst wins over single. The losing commands are dropped.
- R10: After reset all strobes, `busy_o` and `eor_o` are low, and every tap is TAP_DEFAULT.
- R11: At most one strobe, step or load, is active in any cycle, and two step strobes never fall in adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_step_i | input | 1 | Single-step command pulse |
| cmd_burst_i | input | 1 | N-step burst command pulse |
| cmd_default_i | input | 1 | Return-to-default command pulse |
| dir_i | input | 1 | Step direction: 0 increase, 1 decrease |
| unit_id_i | input | ID_W | Target unit ID, 4*channel + kind |
| burst_len_i | input | 8 | Burst length; bits [6:0] used |
| clr_eor_i | input | 1 | Clears the end-of-range flag |
| step_o | output | NUM_EL | One-hot step strobe per element |
| dir_o | output | 1 | Direction accompanying step strobes |
| load_o | output | NUM_EL | One-hot load-default strobe per element |
| busy_o | output | 1 | Adjustment in progress |
| eor_o | output | 1 | Sticky end-of-range flag |

## Verification
The bench drives bursts into both tap limits. A controller that wrapped its shadow count or issued the blocked strobe would move the modelled primitive and leave `eor_o` low. It sends IDs with kind 2 and with an out-of-range channel, and a design that mis-decoded them would strobe a wrong element. It injects a command mid-burst, where a controller that restarted would emit extra strobes. It measures strobe spacing and busy length, so an off-by-one in the settle counter shifts every expected cycle. It also fires commands together and checks the priority order, and it checks that a burst length with bit 7 set is masked to its low seven bits.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    localparam int BURST_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP,
        ST_SETTLE,
        ST_LOAD
    } dsc_state_e;
endpackage

// File: rtl/dsc_unit_decode.sv
module dsc_unit_decode #(
    parameter int NUM_CH = 3,
    parameter int ID_W   = 4,
    parameter int EL_W   = 3
) (
    input  logic [ID_W-1:0] id_i,
    output logic            ok_o,
    output logic [EL_W-1:0] el_o
);
    localparam int CH_W = ID_W - 2;

    logic [CH_W-1:0] ch;
    logic [1:0]      kind;

    assign ch   = id_i[ID_W-1:2];
    assign kind = id_i[1:0];

    // kinds 0 and 1 exist per channel; channels beyond NUM_CH do not
    assign ok_o = !kind[1] && (int'(ch) < NUM_CH);
    assign el_o = EL_W'({ch, kind[0]});
endmodule

// File: rtl/dsc_tap_bank.sv
module dsc_tap_bank #(
    parameter int NUM_EL      = 6,
    parameter int EL_W        = 3,
    parameter int TAP_W       = 6,
    parameter int TAP_DEFAULT = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_en_i,
    input  logic            load_en_i,
    input  logic            dir_i,
    input  logic [EL_W-1:0] sel_i,
    output logic            sel_at_min_o,
    output logic            sel_at_max_o
);
    localparam logic [TAP_W-1:0] DEF_TAP = TAP_W'(TAP_DEFAULT);

    logic [TAP_W-1:0] tap_q [NUM_EL];

    for (genvar i = 0; i < NUM_EL; i++) begin : g_el
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tap_q[i] <= DEF_TAP;
            end else if (int'(sel_i) == i) begin
                if (load_en_i)
                    tap_q[i] <= DEF_TAP;
                else if (step_en_i)
                    tap_q[i] <= dir_i ? tap_q[i] - 1'b1 : tap_q[i] + 1'b1;
            end
        end
    end

    assign sel_at_min_o = (tap_q[sel_i] == '0);
    assign sel_at_max_o = (tap_q[sel_i] == '1);
endmodule

// File: rtl/delay_step_ctrl.sv
module delay_step_ctrl
    import dsc_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter int TAP_W       = 6,
    parameter int TAP_DEFAULT = 32,
    parameter int SETTLE_GAP  = 4,
    localparam int ID_W       = $clog2(4 * NUM_CH),
    localparam int NUM_EL     = 2 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_step_i,
    input  logic              cmd_burst_i,
    input  logic              cmd_default_i,
    input  logic              dir_i,
    input  logic [ID_W-1:0]   unit_id_i,
    input  logic [7:0]        burst_len_i,
    input  logic              clr_eor_i,
    output logic [NUM_EL-1:0] step_o,
    output logic              dir_o,
    output logic [NUM_EL-1:0] load_o,
    output logic              busy_o,
    output logic              eor_o
);
    localparam int EL_W  = (NUM_EL > 1) ? $clog2(NUM_EL) : 1;
    localparam int GAP_W = (SETTLE_GAP > 1) ? $clog2(SETTLE_GAP + 1) : 1;

    dsc_state_e         state_q, state_d;
    logic [EL_W-1:0]    sel_q, sel_d, dec_el;
    logic               dir_q, dir_d, id_ok;
    logic [BURST_W-1:0] remain_q, remain_d, burst_n;
    logic [GAP_W-1:0]   gap_q, gap_d;
    logic               eor_q, eor_d;
    logic               at_min, at_max, blocked, step_fire, load_fire;

    assign burst_n = burst_len_i[BURST_W-1:0];
    assign blocked = dir_q ? at_min : at_max;

    dsc_unit_decode #(.NUM_CH(NUM_CH), .ID_W(ID_W), .EL_W(EL_W)) u_dec (
        .id_i (unit_id_i),
        .ok_o (id_ok),
        .el_o (dec_el)
    );

    dsc_tap_bank #(
        .NUM_EL(NUM_EL), .EL_W(EL_W), .TAP_W(TAP_W), .TAP_DEFAULT(TAP_DEFAULT)
    ) u_taps (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_en_i    (step_fire),
        .load_en_i    (load_fire),
        .dir_i        (dir_q),
        .sel_i        (sel_q),
        .sel_at_min_o (at_min),
        .sel_at_max_o (at_max)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        sel_d    = sel_q;
        dir_d    = dir_q;
        remain_d = remain_q;
        gap_d    = gap_q;
        eor_d    = eor_q;
        if (clr_eor_i)
            eor_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (id_ok && (cmd_default_i || cmd_burst_i || cmd_step_i)) begin
                    sel_d = dec_el;
                    dir_d = dir_i;
                    if (cmd_default_i) begin
                        state_d = ST_LOAD;
                    end else if (cmd_burst_i) begin
                        if (burst_n != '0) begin
                            state_d  = ST_STEP;
                            remain_d = burst_n;
                        end
                    end else begin
                        state_d  = ST_STEP;
                        remain_d = BURST_W'(1);
                    end
                end
            end
            ST_STEP: begin
                if (blocked)
                    eor_d = 1'b1;
                remain_d = remain_q - 1'b1;
                if (remain_q == BURST_W'(1)) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_SETTLE;
                    gap_d   = GAP_W'(SETTLE_GAP - 1);
                end
            end
            ST_SETTLE: begin
                if (gap_q == '0)
                    state_d = ST_STEP;
                else
                    gap_d = gap_q - 1'b1;
            end
            ST_LOAD: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            sel_q    <= '0;
            dir_q    <= 1'b0;
            remain_q <= '0;
            gap_q    <= '0;
            eor_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            sel_q    <= sel_d;
            dir_q    <= dir_d;
            remain_q <= remain_d;
            gap_q    <= gap_d;
            eor_q    <= eor_d;
        end
    end

    // outputs
    always_comb begin
        step_fire = (state_q == ST_STEP) && !blocked;
        load_fire = (state_q == ST_LOAD);
        step_o    = '0;
        load_o    = '0;
        if (step_fire)
            step_o[sel_q] = 1'b1;
        if (load_fire)
            load_o[sel_q] = 1'b1;
        busy_o = (state_q != ST_IDLE);
        dir_o  = dir_q;
        eor_o  = eor_q;
    end
endmodule

// File: rtl/delay_step_ctrl_chk.sv
module dsc_checker #(
    parameter int NUM_EL = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_EL-1:0] step_o,
    input logic [NUM_EL-1:0] load_o,
    input logic              dir_o,
    input logic              busy_o,
    input logic              eor_o,
    input logic              clr_eor_i
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(step_o) + $countones(load_o)) <= 1); // R11

    AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (|step_o) |=> (step_o == '0)); // R11

    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ((|step_o) || (|load_o)) |-> busy_o); // R5

    AST_LOAD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|load_o) |=> !busy_o); // R4

    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !$rose(busy_o)) |-> $stable(dir_o)); // R1

    AST_EOR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (eor_o && !clr_eor_i) |=> eor_o); // R8

    AST_EOR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_eor_i && !busy_o) |=> !eor_o); // R8
endmodule

bind delay_step_ctrl dsc_checker #(.NUM_EL(NUM_EL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_o    (step_o),
    .load_o    (load_o),
    .dir_o     (dir_o),
    .busy_o    (busy_o),
    .eor_o     (eor_o),
    .clr_eor_i (clr_eor_i)
);

// File: tb/tb_delay_step_ctrl.sv
module tb_delay_step_ctrl;
    localparam int NUM_CH  = 3;
    localparam int TAP_W   = 6;
    localparam int TAP_DEF = 32;
    localparam int GAP     = 4;
    localparam int ID_W    = 4;
    localparam int NUM_EL  = 6;
    localparam int TAP_MAX = (1 << TAP_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmd_step_i, cmd_burst_i, cmd_default_i, dir_i, clr_eor_i;
    logic [ID_W-1:0]   unit_id_i;
    logic [7:0]        burst_len_i;
    logic [NUM_EL-1:0] step_o, load_o;
    logic              dir_o, busy_o, eor_o;

    always #5 clk = ~clk;

    delay_step_ctrl #(
        .NUM_CH(NUM_CH), .TAP_W(TAP_W), .TAP_DEFAULT(TAP_DEF), .SETTLE_GAP(GAP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_step_i(cmd_step_i), .cmd_burst_i(cmd_burst_i),
        .cmd_default_i(cmd_default_i), .dir_i(dir_i), .unit_id_i(unit_id_i),
        .burst_len_i(burst_len_i), .clr_eor_i(clr_eor_i), .step_o(step_o),
        .dir_o(dir_o), .load_o(load_o), .busy_o(busy_o), .eor_o(eor_o)
    );

    typedef struct {
        int    cyc;
        bit    is_load;
        int    el;
        bit    dir;
        string req;
    } exp_t;

    exp_t  expq[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    prim_tap[NUM_EL];
    int    model_tap[NUM_EL];
    bit    model_eor;

    always @(posedge clk) cyc <= cyc + 1;

    // saturating model of the analog delay primitives
    always @(posedge clk) begin
        for (int i = 0; i < NUM_EL; i++) begin
            if (!rst_n || load_o[i])
                prim_tap[i] <= TAP_DEF;
            else if (step_o[i])
                prim_tap[i] <= dir_o ? ((prim_tap[i] > 0) ? prim_tap[i] - 1 : 0)
                                     : ((prim_tap[i] < TAP_MAX) ? prim_tap[i] + 1 : TAP_MAX);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: compares every strobe against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && ((|step_o) || (|load_o))) begin
            int el;
            bit is_ld;
            exp_t e;
            el = -1;
            is_ld = |load_o;
            for (int i = 0; i < NUM_EL; i++)
                if (step_o[i] || load_o[i]) el = i;
            if (expq.size() == 0) begin
                chk(1'b0, "R11", "unexpected strobe on element", el, -1);
            end else begin
                e = expq.pop_front();
                chk(e.cyc == cyc, e.req, "strobe cycle", cyc, e.cyc);
                chk(e.el == el, e.req, "strobe element", el, e.el);
                chk(e.is_load == is_ld, e.req, "strobe kind load", int'(is_ld), int'(e.is_load));
                if (!e.is_load)
                    chk(e.dir == dir_o, e.req, "direction", int'(dir_o), int'(e.dir));
            end
        end
    end

    task automatic model_step(input int el, input bit d, input int t, input string req);
        exp_t e;
        if ((d && model_tap[el] == 0) || (!d && model_tap[el] == TAP_MAX)) begin
            model_eor = 1'b1;
        end else begin
            model_tap[el] = d ? model_tap[el] - 1 : model_tap[el] + 1;
            e.cyc = t; e.is_load = 1'b0; e.el = el; e.dir = d; e.req = req;
            expq.push_back(e);
        end
    endtask

    // driver: applies a command for one cycle and pushes expected strobes
    task automatic cmd(input bit st, input bit bu, input bit df, input int id,
                       input bit d, input int n, input string req);
        int c, sub, el, t;
        bit ok;
        exp_t e;
        @(negedge clk);
        cmd_step_i = st; cmd_burst_i = bu; cmd_default_i = df;
        unit_id_i = ID_W'(id); dir_i = d; burst_len_i = 8'(n);
        c = id / 4; sub = id % 4;
        ok = (sub < 2) && (c < NUM_CH);
        el = 2 * c + sub;
        t = cyc + 1;
        if (ok) begin
            if (df) begin
                model_tap[el] = TAP_DEF;
                e.cyc = t; e.is_load = 1'b1; e.el = el; e.dir = 1'b0; e.req = req;
                expq.push_back(e);
            end else if (bu) begin
                for (int k = 0; k < (n % 128); k++)
                    model_step(el, d, t + k * (GAP + 1), req);
            end else if (st) begin
                model_step(el, d, t, req);
            end
        end
        @(negedge clk);
        cmd_step_i = 0; cmd_burst_i = 0; cmd_default_i = 0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int nb;
        rst_n = 0; cmd_step_i = 0; cmd_burst_i = 0; cmd_default_i = 0;
        dir_i = 0; clr_eor_i = 0; unit_id_i = '0; burst_len_i = '0;
        model_eor = 0;
        for (int i = 0; i < NUM_EL; i++) model_tap[i] = TAP_DEF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10 reset state
        chk(step_o == '0 && load_o == '0, "R10", "strobes after reset", int'(step_o | load_o), 0);
        chk(!busy_o, "R10", "busy after reset", int'(busy_o), 0);
        chk(!eor_o, "R10", "eor after reset", int'(eor_o), 0);

        // R1 R2 single steps on capture and IO units
        cmd(1, 0, 0, 0, 0, 0, "R1");
        chk(busy_o, "R5", "busy after single accept", int'(busy_o), 1);
        wait_idle(nb);
        chk(nb == 1, "R5", "single busy length", nb, 1);
        cmd(1, 0, 0, 5, 1, 0, "R2");
        wait_idle(nb);
        chk(prim_tap[3] == TAP_DEF - 1, "R2", "io delay ch1 tap", prim_tap[3], TAP_DEF - 1);

        // R2 invalid IDs ignored
        cmd(1, 0, 0, 2, 0, 0, "R2");
        chk(!busy_o, "R2", "busy on kind-2 id", int'(busy_o), 0);
        cmd(1, 0, 0, 12, 0, 0, "R2");
        chk(!busy_o, "R2", "busy on absent channel", int'(busy_o), 0);

        // R3 burst, bit 7 of length masked, spacing and busy length
        cmd(0, 1, 0, 8, 0, 8'h85, "R3");
        wait_idle(nb);
        chk(nb == 1 + 4 * (GAP + 1), "R5", "burst busy length", nb, 1 + 4 * (GAP + 1));
        chk(prim_tap[4] == TAP_DEF + 5, "R3", "burst final tap", prim_tap[4], TAP_DEF + 5);
        cmd(0, 1, 0, 8, 0, 0, "R3");
        chk(!busy_o, "R3", "busy on zero-length burst", int'(busy_o), 0);

        // R6 command during busy ignored
        cmd(0, 1, 0, 9, 0, 3, "R6");
        cmd_step_i = 1; unit_id_i = ID_W'(0); dir_i = 0;
        @(negedge clk);
        cmd_step_i = 0;
        wait_idle(nb);
        chk(prim_tap[0] == model_tap[0], "R6", "tap of element hit while busy", prim_tap[0], model_tap[0]);

        // R7 R8 run into the top limit
        cmd(0, 1, 0, 1, 0, 40, "R7");
        wait_idle(nb);
        chk(prim_tap[1] == TAP_MAX, "R7", "tap at max", prim_tap[1], TAP_MAX);
        chk(eor_o == model_eor && eor_o, "R7", "eor after max", int'(eor_o), 1);
        repeat (3) @(negedge clk);
        chk(eor_o, "R8", "eor sticky", int'(eor_o), 1);
        clr_eor_i = 1;
        @(negedge clk);
        clr_eor_i = 0;
        model_eor = 0;
        chk(!eor_o, "R8", "eor after clear", int'(eor_o), 0);

        // R4 return to default
        cmd(0, 0, 1, 1, 0, 0, "R4");
        wait_idle(nb);
        chk(nb == 1, "R4", "load busy length", nb, 1);
        chk(prim_tap[1] == TAP_DEF, "R4", "tap after default", prim_tap[1], TAP_DEF);

        // R7 bottom limit
        cmd(0, 1, 0, 0, 1, 40, "R7");
        wait_idle(nb);
        chk(prim_tap[0] == 0, "R7", "tap at min", prim_tap[0], 0);
        chk(eor_o, "R7", "eor after min", int'(eor_o), 1);

        // R9 priority
        cmd(1, 0, 1, 8, 0, 0, "R9");
        wait_idle(nb);
        chk(prim_tap[4] == TAP_DEF, "R9", "default beats step", prim_tap[4], TAP_DEF);
        cmd(1, 1, 0, 4, 0, 2, "R9");
        wait_idle(nb);
        chk(prim_tap[2] == TAP_DEF + 2, "R9", "burst beats step", prim_tap[2], TAP_DEF + 2);

        repeat (4) @(negedge clk);
        for (int i = 0; i < NUM_EL; i++)
            chk(prim_tap[i] == model_tap[i], "R1", "final tap", prim_tap[i], model_tap[i]);
        chk(expq.size() == 0, "R3", "missing strobes", expq.size(), 0);
        summary();
        $finish;
    end
endmodule